// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers single-cycle event pulses from the internal sources of a power-management chip and turns them into one interrupt request for a host processor. Each event lands in a sticky bit of one of five 16-bit secondary status registers. A per-register mask decides whether a pending bit takes part in the summary. The unmasked bits are ORed into a 13-bit primary register with one bit per functional group, and that register is gated by a primary mask before it drives the active-low request pin.

The host reaches every register through a plain synchronous port: a write strobe, a read strobe, a 5-bit address and 16-bit data. Read data comes back one cycle after the read strobe, together with a valid pulse. The host clears status by writing ones back to the secondary status registers. A configuration bit chooses whether the pin drives both levels or only pulls low with an output-enable.

Top module: `irq_aggr_ctrl`

## Requirements
- R1: After reset all five secondary masks read 0xFFFF, the primary mask reads 0x1FFF, the configuration register and every status register read 0, and the pin is inactive (irq_n_o=1, irq_oe_o=1).
- R2: An event pulse on a mapped source sets its status bit at the next clock edge, whether or not that bit is masked, and the bit stays set until the host clears it.
- R3: Writing a secondary status register (addresses 0x08..0x0C for registers 1..5) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A secondary mask bit at 1 (mask registers at 0x10..0x14, paired with status registers 1..5) keeps its pending status bit out of the primary register. Mask bit 0 lets it through.
- R6: Primary register (address 0x00, read-only) bit positions and sources: bit0 temperature (reg1 bit0), bit1 on-key (reg1 bit1), bit2 power path (reg1 bits2-4), bit3 watchdog (reg1 bit5), bit4 clock/alarm (reg1 bits6-7), bit5 pen-down (reg1 bit8), bit6 touch data (reg1 bit9), bit7 ADC (reg1 bits10-14), bit8 charger (reg2 bits0-7), bit9 current sink (reg2 bits8-9), bit11 high-current (reg4 bits4-5), bit12 GPIO (reg5 bits0-15).
- R7: Primary bit10 (undervoltage) is the OR of unmasked regulator faults in reg3 bits0-9 and unmasked converter faults in reg4 bits0-3.
- R8: The primary mask (address 0x01, bit n gates primary bit n, 1 = blocked) gates the primary bits into the pin. Writing 0 enables all groups. The request is active while any unblocked primary bit is set.
- R9: Configuration bit0 (address 0x02) selects the pin mode. At 0 the pin is push-pull: irq_oe_o=1 and irq_n_o low while active. At 1 it is open-drain: irq_n_o=0 and irq_oe_o=1 only while active.
- R10: A read returns the addressed register one cycle later with rvalid_o high for exactly that cycle and changes no state. Writes to the primary register are ignored, and unmapped addresses read 0.
- R11: Status bits with no source (reg1 bit15, reg2 bits10-15, reg3 bits10-15, reg4 bits6-15) never set and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 80 | Event pulses; bit 16*k+b feeds status register k+1 bit b |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response strobe |
| irq_n_o | output | 1 | Interrupt request level, active low |
| irq_oe_o | output | 1 | Pin output enable |

## Verification
On every cycle the assertions check the following. Event bits land in status and stay set even against a clear. Status bits fall only through a host write, and status holds when there is neither a write nor an event. The pin follows the gated primary bits in both modes. Fully masked secondaries leave the primary register empty, and each read strobe is followed by exactly one response. The source-to-group map, the undervoltage span across two registers, the exact values read back and the ignored bits and addresses can only be shown by the bench's scenarios, which compare read data against values worked out from the requirements.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

  localparam int unsigned NUM_SEC = 5;
  localparam int unsigned SEC_W   = 16;
  localparam int unsigned ADDR_W  = 5;

  typedef enum int unsigned {
    GRP_TEMP  = 0,
    GRP_ONKEY = 1,
    GRP_PWR   = 2,
    GRP_WDOG  = 3,
    GRP_RTC   = 4,
    GRP_PEN   = 5,
    GRP_TDATA = 6,
    GRP_ADC   = 7,
    GRP_CHG   = 8,
    GRP_CSINK = 9,
    GRP_UV    = 10,
    GRP_HICUR = 11,
    GRP_GPIO  = 12,
    GRP_COUNT = 13
  } grp_e;

  localparam int unsigned NUM_GRP = GRP_COUNT;

  localparam logic [ADDR_W-1:0] ADR_PRIM  = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_PMASK = 5'h01;
  localparam logic [ADDR_W-1:0] ADR_CFG   = 5'h02;
  localparam logic [ADDR_W-1:0] ADR_STAT0 = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_MASK0 = 5'h10;

  // source bits of secondary register sec that feed group grp
  function automatic logic [SEC_W-1:0] src_map(int unsigned sec, grp_e grp);
    logic [SEC_W-1:0] m;
    m = '0;
    case (sec)
      0: case (grp)
           GRP_TEMP:  m = 16'h0001;
           GRP_ONKEY: m = 16'h0002;
           GRP_PWR:   m = 16'h001C;
           GRP_WDOG:  m = 16'h0020;
           GRP_RTC:   m = 16'h00C0;
           GRP_PEN:   m = 16'h0100;
           GRP_TDATA: m = 16'h0200;
           GRP_ADC:   m = 16'h7C00;
           default:   m = '0;
         endcase
      1: case (grp)
           GRP_CHG:   m = 16'h00FF;
           GRP_CSINK: m = 16'h0300;
           default:   m = '0;
         endcase
      2: case (grp)
           GRP_UV:    m = 16'h03FF;
           default:   m = '0;
         endcase
      3: case (grp)
           GRP_UV:    m = 16'h000F;
           GRP_HICUR: m = 16'h0030;
           default:   m = '0;
         endcase
      4: case (grp)
           GRP_GPIO:  m = 16'hFFFF;
           default:   m = '0;
         endcase
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [SEC_W-1:0] sec_valid(int unsigned sec);
    logic [SEC_W-1:0] v;
    v = '0;
    for (int unsigned g = 0; g < NUM_GRP; g++) v |= src_map(sec, grp_e'(g));
    return v;
  endfunction

endpackage

// File: rtl/irq_sec_bank.sv
module irq_sec_bank #(
  parameter int unsigned      W     = 16,
  parameter logic [W-1:0]     VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         stat_we_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] stat_q, mask_q, clr, set;

  assign clr = stat_we_i ? wdata_i : '0;
  assign set = evt_i & VALID;

  // set after clear: a pulse coinciding with an acknowledge survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (mask_we_i) mask_q <= wdata_i;
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = stat_q & ~mask_q;

  AST_EVT_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set) |=> ((stat_o & $past(evt_i & VALID)) == $past(evt_i & VALID))); // R2 R4

  AST_FALL_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we_i |=> ((~stat_o & $past(stat_o)) == '0)); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && evt_i == '0) |=> ((stat_o & $past(wdata_i)) == '0)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_we_i && evt_i == '0) |=> $stable(stat_o)); // R10

endmodule

// File: rtl/irq_group_or.sv
module irq_group_or
  import irq_aggr_pkg::*;
(
  input  logic [NUM_SEC-1:0][SEC_W-1:0] pend_i,
  output logic [NUM_GRP-1:0]            prim_o
);

  always_comb begin
    for (int unsigned g = 0; g < NUM_GRP; g++) begin
      prim_o[g] = 1'b0;
      for (int unsigned s = 0; s < NUM_SEC; s++)
        prim_o[g] = prim_o[g] | (|(pend_i[s] & src_map(s, grp_e'(g))));
    end
  end

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
  input  logic active_i,
  input  logic od_sel_i,
  output logic irq_n_o,
  output logic irq_oe_o
);

  // open-drain: level pinned low, enable carries the request
  assign irq_n_o  = od_sel_i ? 1'b0 : ~active_i;
  assign irq_oe_o = od_sel_i ? active_i : 1'b1;

endmodule

// File: rtl/irq_aggr_ctrl.sv
module irq_aggr_ctrl
  import irq_aggr_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SEC*SEC_W-1:0] evt_i,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [SEC_W-1:0]         wdata_i,
  output logic [SEC_W-1:0]         rdata_o,
  output logic                     rvalid_o,
  output logic                     irq_n_o,
  output logic                     irq_oe_o
);

  logic [NUM_SEC-1:0][SEC_W-1:0] stat, msk, pend;
  logic [NUM_GRP-1:0]            prim, pmask_q;
  logic                          cfg_od_q;
  logic                          active;
  logic [SEC_W-1:0]              rd_mux;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    logic stat_we, mask_we;
    assign stat_we = wr_en_i && (addr_i == ADR_STAT0 + ADDR_W'(s));
    assign mask_we = wr_en_i && (addr_i == ADR_MASK0 + ADDR_W'(s));

    irq_sec_bank #(
      .W     (SEC_W),
      .VALID (sec_valid(s))
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i[s*SEC_W +: SEC_W]),
      .stat_we_i (stat_we),
      .mask_we_i (mask_we),
      .wdata_i   (wdata_i),
      .stat_o    (stat[s]),
      .mask_o    (msk[s]),
      .pend_o    (pend[s])
    );
  end

  irq_group_or u_or (
    .pend_i (pend),
    .prim_o (prim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pmask_q  <= '1;
      cfg_od_q <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == ADR_PMASK) pmask_q  <= wdata_i[NUM_GRP-1:0];
      if (addr_i == ADR_CFG)   cfg_od_q <= wdata_i[0];
    end
  end

  assign active = |(prim & ~pmask_q);

  irq_pin_drv u_pin (
    .active_i (active),
    .od_sel_i (cfg_od_q),
    .irq_n_o  (irq_n_o),
    .irq_oe_o (irq_oe_o)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADR_PRIM)  rd_mux = SEC_W'(prim);
    if (addr_i == ADR_PMASK) rd_mux = SEC_W'(pmask_q);
    if (addr_i == ADR_CFG)   rd_mux = SEC_W'(cfg_od_q);
    for (int unsigned s = 0; s < NUM_SEC; s++) begin
      if (addr_i == ADR_STAT0 + ADDR_W'(s)) rd_mux = stat[s];
      if (addr_i == ADR_MASK0 + ADDR_W'(s)) rd_mux = msk[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  AST_PP_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_od_q |-> (irq_oe_o && (irq_n_o == ~|(prim & ~pmask_q)))); // R8

  AST_OD_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_od_q |-> (!irq_n_o && (irq_oe_o == |(prim & ~pmask_q)))); // R9

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&msk) |-> (prim == '0)); // R5

  AST_RD_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o); // R10

  AST_NO_SPUR_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o); // R10

endmodule

// File: tb/irq_aggr_ctrl_tb_top.sv
module irq_aggr_ctrl_tb_top;
  import irq_aggr_pkg::*;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic [NUM_SEC*SEC_W-1:0] evt = '0;
  logic                     wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0]        addr = '0;
  logic [SEC_W-1:0]         wdata = '0;
  logic [SEC_W-1:0]         rdata;
  logic                     rvalid, irq_n, irq_oe;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic [SEC_W-1:0] exp_q[$];
  string            tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  irq_aggr_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .irq_n_o(irq_n), .irq_oe_o(irq_oe)
  );

  task automatic chk(string tag, logic [SEC_W-1:0] act, logic [SEC_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk("R10 unexpected response", 16'h0001, 16'h0000);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic rd(logic [ADDR_W-1:0] a, logic [SEC_W-1:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [SEC_W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(int unsigned sec, logic [SEC_W-1:0] bits);
    @(negedge clk);
    evt[sec*SEC_W +: SEC_W] = bits;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic wr_pulse(logic [ADDR_W-1:0] a, logic [SEC_W-1:0] d,
                          int unsigned sec, logic [SEC_W-1:0] bits);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    evt[sec*SEC_W +: SEC_W] = bits;
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
  endtask

  task automatic pin(logic en, logic oe, string tag);
    @(negedge clk);
    chk({tag, " irq_n"}, SEC_W'(irq_n), SEC_W'(en));
    chk({tag, " irq_oe"}, SEC_W'(irq_oe), SEC_W'(oe));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int s = 0; s < 5; s++) rd(ADR_MASK0 + ADDR_W'(s), 16'hFFFF, "R1 sec mask");
    for (int s = 0; s < 5; s++) rd(ADR_STAT0 + ADDR_W'(s), 16'h0000, "R1 status");
    rd(ADR_PMASK, 16'h1FFF, "R1 pmask");
    rd(ADR_CFG, 16'h0000, "R1 cfg");
    rd(ADR_PRIM, 16'h0000, "R1 prim");
    pin(1'b1, 1'b1, "R1");

    // R2 set while masked, R5 kept out of summary
    pulse(0, 16'h0001);
    rd(5'h08, 16'h0001, "R2 set while masked");
    rd(ADR_PRIM, 16'h0000, "R5 masked source");
    pin(1'b1, 1'b1, "R5");
    repeat (5) @(negedge clk);
    rd(5'h08, 16'h0001, "R2 sticky");

    // R6 / R8
    wr(5'h10, 16'hFFFE);
    rd(ADR_PRIM, 16'h0001, "R6 temperature");
    pin(1'b1, 1'b1, "R8 primary masked");
    wr(ADR_PMASK, 16'h0000);
    pin(1'b0, 1'b1, "R8 enabled");

    // R3 write-one-to-clear
    wr(5'h08, 16'h0000);
    rd(5'h08, 16'h0001, "R3 zero keeps");
    wr(5'h08, 16'h0001);
    rd(5'h08, 16'h0000, "R3 one clears");
    pin(1'b1, 1'b1, "R3 released");

    // R4 set wins over clear
    pulse(4, 16'h0018);
    rd(5'h0C, 16'h0018, "R2 gpio status");
    wr_pulse(5'h0C, 16'h0018, 4, 16'h0008);
    rd(5'h0C, 16'h0008, "R4 collision");
    rd(ADR_PRIM, 16'h0000, "R5 gpio masked");

    // R7 undervoltage across two registers
    wr(5'h12, 16'h0000);
    wr(5'h13, 16'h0000);
    pulse(2, 16'h0200);
    rd(ADR_PRIM, 16'h0400, "R7 regulator fault");
    pin(1'b0, 1'b1, "R7");
    wr(5'h0A, 16'h0200);
    rd(ADR_PRIM, 16'h0000, "R7 cleared");
    pulse(3, 16'h0001);
    rd(ADR_PRIM, 16'h0400, "R7 converter fault");
    pulse(3, 16'h0010);
    rd(ADR_PRIM, 16'h0C00, "R6 high-current");
    wr(ADR_PMASK, 16'h0C00);
    pin(1'b1, 1'b1, "R8 groups blocked");
    wr(ADR_PMASK, 16'h0400);
    pin(1'b0, 1'b1, "R8 one group open");
    wr(ADR_PMASK, 16'h0000);
    wr(5'h14, 16'h0000);
    rd(ADR_PRIM, 16'h1C00, "R6 gpio group");
    wr(5'h0B, 16'h003F);
    wr(5'h0C, 16'hFFFF);
    rd(ADR_PRIM, 16'h0000, "R3 all cleared");

    // R6 remaining groups
    wr(5'h11, 16'h0000);
    pulse(1, 16'h0380);
    rd(ADR_PRIM, 16'h0300, "R6 charger and sink");
    wr(5'h10, 16'h0000);
    pulse(0, 16'h0142);
    rd(ADR_PRIM, 16'h0332, "R6 onkey rtc pen");
    pulse(0, 16'h0600);
    rd(ADR_PRIM, 16'h03F2, "R6 touch data adc");
    wr(5'h10, 16'h0100);
    rd(ADR_PRIM, 16'h03D2, "R5 single bit mask");
    wr(5'h10, 16'h0000);

    // R9 open-drain
    wr(ADR_CFG, 16'h0001);
    pin(1'b0, 1'b1, "R9 od active");
    wr(5'h08, 16'hFFFF);
    wr(5'h09, 16'hFFFF);
    rd(ADR_PRIM, 16'h0000, "R3 cleared again");
    pin(1'b0, 1'b0, "R9 od released");
    wr(ADR_CFG, 16'h0000);
    pin(1'b1, 1'b1, "R9 push-pull idle");

    // R11 unused bits
    pulse(3, 16'h8040);
    rd(5'h0B, 16'h0000, "R11 reg4 unused");
    pulse(0, 16'h8000);
    rd(5'h08, 16'h0000, "R11 reg1 unused");
    pulse(1, 16'hFC00);
    rd(5'h09, 16'h0000, "R11 reg2 unused");
    pin(1'b1, 1'b1, "R11 no request");

    // R10 reads and ignored writes
    pulse(4, 16'h0001);
    rd(5'h0C, 16'h0001, "R10 status");
    rd(ADR_PRIM, 16'h1000, "R10 prim read 1");
    rd(ADR_PRIM, 16'h1000, "R10 prim read 2");
    rd(5'h0C, 16'h0001, "R10 status unchanged");
    wr(ADR_PRIM, 16'hFFFF);
    rd(ADR_PRIM, 16'h1000, "R10 prim write ignored");
    rd(5'h1F, 16'h0000, "R10 unmapped");
    wr(ADR_CFG, 16'hFFFE);
    rd(ADR_CFG, 16'h0000, "R9 cfg bit0 only");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk("R10 missing response", 16'(exp_q.size()), 16'h0000);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule